// File: doc/BRIEF.md
# Memory-Mapped Serial Master Port with FIFOs

This block is a synchronous serial master that a processor drives through a small register window. Software sets the frame width (4 to 16 bits) and a clock prescale value, pushes words into an 8-entry transmit queue through the data register, and pulls received words from an 8-entry receive queue through the same address. A shift engine takes one word at a time from the transmit queue, sends it MSB first on `mosi` with `sclk` idling low and `cs_n` held low for the frame, samples `miso` on each rising `sclk` edge, and stores the received word. In loopback mode the engine copies the transmit word straight into the receive queue and leaves the pins idle.

The engine never overruns the receive queue: a frame starts only when the transmit queue holds a word and the receive queue has a free slot, so a full receive queue holds transmission back until software reads. A status register, raw and masked interrupt views, a level interrupt output driven by half-full thresholds, and eight read-only identification bytes complete the register window.

The engine is a four-state machine. `ENG_IDLE` waits for a start condition; it goes to `ENG_SHIFT_LO` when a frame starts with loopback off, or to `ENG_DELIVER` when it starts with loopback on. `ENG_SHIFT_LO` holds `sclk` low for one half period and then goes to `ENG_SHIFT_HI`, which samples `miso` on entry. After its half period `ENG_SHIFT_HI` goes back to `ENG_SHIFT_LO` (shifting the next bit onto `mosi`) while bits remain, or to `ENG_DELIVER` after the last bit. `ENG_DELIVER` writes the received word into the receive queue and returns to `ENG_IDLE`.

Top module: `spi_fifo_port`

## Requirements
- R1: After reset the status register reads 0x03, the raw interrupt register reads 0x08, the mask reads 0, `irq` is low, `cs_n` is high and `sclk` is low.
- R2: Byte offset 0x00 (frame control; bits 3:0 are width minus one) reads back as written; offset 0x04 (port control) keeps bits 3:0; offset 0x10 (prescale) keeps bits 7:0; offset 0x14 (interrupt mask) keeps bits 3:0; offset 0x20 and any unmapped offset read 0.
- R3: Offsets 0xFE0, 0xFE4, ... 0xFFC read the identification bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R4: Status at 0x0C: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full, bit4 busy (transmit queue holds a word).
- R5: The transmit queue holds 8 words; a data-register write (offset 0x08) while it is full is dropped.
- R6: A data-register read while the receive queue is empty returns 0 and changes no state.
- R7: Words are ANDed with a mask of (width) ones when written into the transmit queue and when stored into the receive queue.
- R8: While port-control bit1 (enable) is clear, no frame starts and `cs_n` stays high.
- R9: With port-control bit0 (loopback) set, each transmit word lands in the receive queue and `cs_n` stays high.
- R10: A frame starts only when the receive queue has room; with the receive queue full the transmit queue keeps its words until software reads, and no received word is lost.
- R11: Raw interrupt (0x18) bit2 is set when the receive queue holds 4 or more words and bit3 when the transmit queue holds 4 or fewer; masked status (0x1C) is raw AND mask and `irq` is its OR.
- R12: Each frame holds `cs_n` low throughout, sends MSB first with `mosi` changing as `sclk` falls, samples `miso` as `sclk` rises, and `sclk` has a period of 2×(max(prescale,1)+1) clocks.
- R13: Words leave each queue in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the access |
| irq | output | 1 | Level interrupt, OR of masked raw status |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low frame select |

## Verification
The bench fills the transmit queue while the port is off and then writes a ninth word; a design that accepted it would corrupt the oldest entry or drop the fourth word off the end. It lets the receive queue fill with words still waiting to send: a design without the stall would start a ninth frame and lose a received word, which shows up as a wrong value or a wrong frame count at the pins. It walks the interrupt thresholds across the 4-word boundary in both queues, where an off-by-one comparison flips the raw bits, and uses a 4-bit frame with high bits set in both directions, where a missing mask leaks the upper bits.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

    localparam logic [11:0] OFF_FRAME  = 12'h000;
    localparam logic [11:0] OFF_PORT   = 12'h004;
    localparam logic [11:0] OFF_DATA   = 12'h008;
    localparam logic [11:0] OFF_STATUS = 12'h00C;
    localparam logic [11:0] OFF_PRESC  = 12'h010;
    localparam logic [11:0] OFF_IMASK  = 12'h014;
    localparam logic [11:0] OFF_IRAW   = 12'h018;
    localparam logic [11:0] OFF_IMSK   = 12'h01C;
    localparam logic [11:0] OFF_DMA    = 12'h020;
    localparam logic [11:0] OFF_ID_LO  = 12'hFE0;
    localparam logic [11:0] OFF_ID_HI  = 12'hFFC;

    localparam int PC_LOOP   = 0;
    localparam int PC_ENABLE = 1;

    localparam int ST_TX_EMPTY = 0;
    localparam int ST_TX_ROOM  = 1;
    localparam int ST_RX_AVAIL = 2;
    localparam int ST_RX_FULL  = 3;
    localparam int ST_BUSY     = 4;

    localparam int IRQ_RX_LVL = 2;
    localparam int IRQ_TX_LVL = 3;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT_LO,
        ENG_SHIFT_HI,
        ENG_DELIVER
    } eng_state_t;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0: b = 8'h22;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
`timescale 1ns/1ps
module spi_word_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    wr_next;
    logic [PW-1:0]    rd_next;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);

    generate
        if ((1 << PW) == DEPTH) begin : g_pow2_wrap
            assign wr_next = wr_ptr + 1'b1;
            assign rd_next = rd_ptr + 1'b1;
        end else begin : g_cmp_wrap
            assign wr_next = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_next = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_next;
            end
            if (do_pop) begin
                rd_ptr <= rd_next;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = store[rd_ptr];

endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_port_pkg::*;
#(
    parameter int DW = 16,
    parameter int HW = 9,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          loopback,
    input  logic [IW-1:0] frame_m1,
    input  logic [HW-1:0] half_len,
    input  logic [DW-1:0] tx_word,
    input  logic          tx_avail,
    input  logic          rx_room,
    input  logic          miso,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n
);

    eng_state_t    state;
    eng_state_t    nxt_state;
    logic [HW-1:0] phase_cnt;
    logic [IW-1:0] bits_left;
    logic [IW-1:0] msb_idx;
    logic [DW-1:0] tx_sh;
    logic [DW-1:0] rx_sh;
    logic          loop_frame;
    logic          start;
    logic          half_done;
    logic          in_frame;

    assign start     = enable && tx_avail && rx_room;
    assign half_done = (phase_cnt == half_len - 1'b1);

    // next-state decision
    always_comb begin
        nxt_state = state;
        unique case (state)
            ENG_IDLE: begin
                if (start) begin
                    nxt_state = loopback ? ENG_DELIVER : ENG_SHIFT_LO;
                end
            end
            ENG_SHIFT_LO: begin
                if (half_done) begin
                    nxt_state = ENG_SHIFT_HI;
                end
            end
            ENG_SHIFT_HI: begin
                if (half_done) begin
                    nxt_state = (bits_left == '0) ? ENG_DELIVER : ENG_SHIFT_LO;
                end
            end
            ENG_DELIVER: begin
                nxt_state = ENG_IDLE;
            end
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            phase_cnt  <= '0;
            bits_left  <= '0;
            msb_idx    <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            loop_frame <= 1'b0;
        end else begin
            state <= nxt_state;
            if (state != nxt_state) begin
                phase_cnt <= '0;
            end else if (state == ENG_SHIFT_LO || state == ENG_SHIFT_HI) begin
                phase_cnt <= phase_cnt + 1'b1;
            end
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        tx_sh      <= tx_word;
                        rx_sh      <= '0;
                        bits_left  <= frame_m1;
                        msb_idx    <= frame_m1;
                        loop_frame <= loopback;
                    end
                end
                ENG_SHIFT_LO: begin
                    if (half_done) begin
                        rx_sh <= {rx_sh[DW-2:0], miso};
                    end
                end
                ENG_SHIFT_HI: begin
                    if (half_done && bits_left != '0) begin
                        tx_sh     <= {tx_sh[DW-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                    end
                end
                ENG_DELIVER: begin
                    loop_frame <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        in_frame = (state == ENG_SHIFT_LO) || (state == ENG_SHIFT_HI);
        tx_pop   = (state == ENG_IDLE) && start;
        rx_push  = (state == ENG_DELIVER);
        rx_word  = loop_frame ? tx_sh : rx_sh;
        sclk     = (state == ENG_SHIFT_HI);
        cs_n     = !in_frame;
        mosi     = in_frame ? tx_sh[msb_idx] : 1'b0;
    end

endmodule

// File: rtl/spi_fifo_port.sv
`timescale 1ns/1ps
module spi_fifo_port
    import spi_port_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    parameter int PSW   = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DW),
    localparam int HW   = PSW + 1,
    localparam int MARK = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);

    logic [DW-1:0]  frame_reg;
    logic [3:0]     port_reg;
    logic [PSW-1:0] presc_reg;
    logic [3:0]     imask_reg;
    logic [DW-1:0]  rd_mux;

    logic           acc_wr;
    logic           acc_rd;
    logic           wr_data;
    logic           rd_data;

    logic [DW:0]    mask_wide;
    logic [DW-1:0]  width_mask;
    logic [HW-1:0]  half_len;

    logic [CW-1:0]  tx_count;
    logic [CW-1:0]  rx_count;
    logic [DW-1:0]  tx_head;
    logic [DW-1:0]  rx_head;
    logic           tx_push;
    logic           rx_pop;
    logic           eng_tx_pop;
    logic           eng_rx_push;
    logic [DW-1:0]  eng_rx_word;

    logic [4:0]     status;
    logic [3:0]     raw_irq;
    logic [3:0]     msk_irq;

    assign acc_wr  = bus_valid && bus_write;
    assign acc_rd  = bus_valid && !bus_write;
    assign wr_data = acc_wr && (bus_addr == AW'(OFF_DATA));
    assign rd_data = acc_rd && (bus_addr == AW'(OFF_DATA));

    assign mask_wide  = ((DW+1)'(1) << ({1'b0, frame_reg[IW-1:0]} + (IW+1)'(1))) - (DW+1)'(1);
    assign width_mask = mask_wide[DW-1:0];
    assign half_len   = ((presc_reg == '0) ? HW'(1) : HW'(presc_reg)) + HW'(1);

    assign tx_push = wr_data && (tx_count != CW'(DEPTH));
    assign rx_pop  = rd_data && (rx_count != '0);

    spi_word_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (bus_wdata & width_mask),
        .pop       (eng_tx_pop),
        .head      (tx_head),
        .count     (tx_count)
    );

    spi_word_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_rx_push),
        .push_data (eng_rx_word & width_mask),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count)
    );

    spi_shift_engine #(.DW(DW), .HW(HW)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (port_reg[PC_ENABLE]),
        .loopback (port_reg[PC_LOOP]),
        .frame_m1 (frame_reg[IW-1:0]),
        .half_len (half_len),
        .tx_word  (tx_head),
        .tx_avail (tx_count != '0),
        .rx_room  (rx_count != CW'(DEPTH)),
        .miso     (miso),
        .tx_pop   (eng_tx_pop),
        .rx_push  (eng_rx_push),
        .rx_word  (eng_rx_word),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

    always_comb begin
        status              = '0;
        status[ST_TX_EMPTY] = (tx_count == '0);
        status[ST_TX_ROOM]  = (tx_count != CW'(DEPTH));
        status[ST_RX_AVAIL] = (rx_count != '0);
        status[ST_RX_FULL]  = (rx_count == CW'(DEPTH));
        status[ST_BUSY]     = (tx_count != '0);
        raw_irq             = '0;
        raw_irq[IRQ_RX_LVL] = (rx_count >= CW'(MARK));
        raw_irq[IRQ_TX_LVL] = (tx_count <= CW'(MARK));
        msk_irq             = raw_irq & imask_reg;
    end

    assign irq = |msk_irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_reg <= '0;
            port_reg  <= '0;
            presc_reg <= '0;
            imask_reg <= '0;
        end else if (acc_wr) begin
            case (bus_addr)
                AW'(OFF_FRAME): frame_reg <= bus_wdata;
                AW'(OFF_PORT):  port_reg  <= bus_wdata[3:0];
                AW'(OFF_PRESC): presc_reg <= bus_wdata[PSW-1:0];
                AW'(OFF_IMASK): imask_reg <= bus_wdata[3:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr >= AW'(OFF_ID_LO) && bus_addr <= AW'(OFF_ID_HI) + AW'(3)) begin
            rd_mux = DW'(ident_byte(bus_addr[4:2]));
        end else begin
            case (bus_addr)
                AW'(OFF_FRAME):  rd_mux = frame_reg;
                AW'(OFF_PORT):   rd_mux = DW'(port_reg);
                AW'(OFF_DATA):   rd_mux = (rx_count != '0) ? rx_head : '0;
                AW'(OFF_STATUS): rd_mux = DW'(status);
                AW'(OFF_PRESC):  rd_mux = DW'(presc_reg);
                AW'(OFF_IMASK):  rd_mux = DW'(imask_reg);
                AW'(OFF_IRAW):   rd_mux = DW'(raw_irq);
                AW'(OFF_IMSK):   rd_mux = DW'(msk_irq);
                default:         rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (acc_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/spi_fifo_port_chk.sv
`timescale 1ns/1ps
module spi_fifo_port_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic [3:0]    imask,
    input logic          irq,
    input logic          cs_n,
    input logic          sclk,
    input logic          enable,
    input logic          wr_data,
    input logic          rd_data,
    input logic [DW-1:0] bus_rdata
);

    a_r12_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r8_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && cs_n) |=> cs_n);

    a_r10_stall_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH)) |=> (tx_count >= $past(tx_count)));

    a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_count == CW'(DEPTH)) |=> (tx_count <= $past(tx_count)));

    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_count == '0) |=> (bus_rdata == '0));

    a_r11_irq_levels: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (((rx_count >= CW'(DEPTH/2)) && imask[2]) ||
                ((tx_count <= CW'(DEPTH/2)) && imask[3])));

    a_r10_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH) && !rd_data) |=> (rx_count == CW'(DEPTH)));

endmodule

bind spi_fifo_port spi_fifo_port_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .imask     (imask_reg),
    .irq       (irq),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .enable    (port_reg[1]),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .bus_rdata (bus_rdata)
);

// File: tb/spi_fifo_port_tb.sv
`timescale 1ns/1ps
module spi_fifo_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        cs_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_fifo_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // behavioural serial slave model
    int          fs = 16;
    int          frames = 0;
    int          bitcnt = 0;
    logic [15:0] cur_reply;
    logic [15:0] cap;
    logic [15:0] mosi_q[$];
    int          last_rise = 0;
    int          last_period = 0;
    bit          first_rise = 1;

    function automatic logic [15:0] reply_of(input int k);
        return 16'(16'hC35A ^ (k * 16'h0F1D));
    endfunction

    function automatic logic [15:0] mask_of(input int w);
        return 16'((32'h1 << w) - 1);
    endfunction

    always @(negedge cs_n) begin
        cur_reply = reply_of(frames);
        bitcnt = 0;
        cap = '0;
        first_rise = 1;
        miso = cur_reply[fs-1];
    end
    always @(posedge sclk) begin
        cap = {cap[14:0], mosi};
        bitcnt = bitcnt + 1;
        if (!first_rise) last_period = cyc - last_rise;
        last_rise = cyc;
        first_rise = 0;
    end
    always @(negedge sclk) begin
        if (bitcnt < fs) miso = cur_reply[fs-1-bitcnt];
    end
    always @(posedge cs_n) begin
        if (rst_n) begin
            mosi_q.push_back(cap);
            frames = frames + 1;
        end
    end

    // per-clock pin monitor
    int pin_viol = 0;
    int cs_low_cycles = 0;
    always @(negedge clk) begin
        if (rst_n && cs_n && sclk) pin_viol++;
        if (rst_n && !cs_n) cs_low_cycles++;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int cs_before;
        repeat (4) @(negedge clk);
        rst_n = 1;
        idle(2);

        // R1 reset state
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 irq", irq, 0);
        rd(12'h00C, d); chk("R1 status", d, 16'h03);
        rd(12'h018, d); chk("R1 raw", d, 16'h08);
        rd(12'h014, d); chk("R1 mask", d, 16'h0);

        // R2 register map
        wr(12'h000, 16'hA5F7); rd(12'h000, d); chk("R2 frame reg", d, 16'hA5F7);
        wr(12'h000, 16'h0007);
        wr(12'h010, 16'h01FF); rd(12'h010, d); chk("R2 prescale 8 bits", d, 16'h00FF);
        wr(12'h010, 16'h0000);
        wr(12'h004, 16'h00F0); rd(12'h004, d); chk("R2 port reg 4 bits", d, 16'h0);
        wr(12'h014, 16'h00F3); rd(12'h014, d); chk("R2 mask 4 bits", d, 16'h3);
        wr(12'h014, 16'h0000);
        wr(12'h020, 16'h0001); rd(12'h020, d); chk("R2 dma reads zero", d, 16'h0);
        rd(12'h040, d); chk("R2 unmapped", d, 16'h0);

        // R3 ident bytes
        begin
            logic [7:0] idv [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            for (int i = 0; i < 8; i++) begin
                rd(12'hFE0 + 12'(i*4), d);
                chk($sformatf("R3 id%0d", i), d, {8'h00, idv[i]});
            end
        end

        // R6 empty read
        rd(12'h008, d); chk("R6 empty read", d, 16'h0);
        rd(12'h00C, d); chk("R6 status unchanged", d, 16'h03);

        // R5/R7/R8 fill while disabled, 8-bit frames
        for (int i = 0; i < 9; i++) wr(12'h008, 16'(16'h0100 | (i * 16'h11)));
        idle(60);
        rd(12'h00C, d); chk("R5 R4 full tx status", d, 16'h10);
        rd(12'h018, d); chk("R11 raw tx 8 words", d, 16'h00);
        chk("R8 no frame while off", cs_low_cycles, 0);

        // R9 loopback
        wr(12'h004, 16'h0003);
        idle(60);
        chk("R9 pins idle in loopback", cs_low_cycles, 0);
        rd(12'h00C, d); chk("R4 R10 rx full status", d, 16'h0F);
        rd(12'h018, d); chk("R11 raw both", d, 16'h0C);
        wr(12'h014, 16'h0004);
        idle(1); chk("R11 irq on", irq, 1);
        rd(12'h01C, d); chk("R11 masked", d, 16'h04);
        wr(12'h014, 16'h0000);
        idle(1); chk("R11 irq off", irq, 0);
        for (int i = 0; i < 8; i++) begin
            rd(12'h008, d); chk($sformatf("R13 R7 loop word %0d", i), d, 16'((i * 16'h11) & 16'hFF));
        end
        rd(12'h00C, d); chk("R4 drained", d, 16'h03);

        // R11 thresholds, 16-bit loopback
        wr(12'h004, 16'h0001);
        wr(12'h000, 16'h000F);
        for (int i = 0; i < 4; i++) wr(12'h008, 16'(16'hBEE0 + i));
        rd(12'h018, d); chk("R11 tx at 4", d, 16'h08);
        wr(12'h008, 16'hBEE4);
        rd(12'h018, d); chk("R11 tx at 5", d, 16'h00);
        wr(12'h014, 16'h000C);
        idle(1); chk("R11 irq low", irq, 0);
        wr(12'h004, 16'h0003);
        idle(30);
        rd(12'h018, d); chk("R11 rx at 5", d, 16'h0C);
        chk("R11 irq high", irq, 1);
        rd(12'h008, d); chk("R13 order 0", d, 16'hBEE0);
        rd(12'h008, d); chk("R13 order 1", d, 16'hBEE1);
        rd(12'h018, d); chk("R11 rx at 3", d, 16'h08);
        for (int i = 2; i < 5; i++) begin
            rd(12'h008, d); chk("R13 order tail", d, 16'(16'hBEE0 + i));
        end
        wr(12'h014, 16'h0000);

        // R10 R12 stall with real pins
        wr(12'h004, 16'h0000);
        fs = 16;
        for (int i = 0; i < 8; i++) wr(12'h008, 16'(16'h1000 + i * 16'h0111));
        wr(12'h004, 16'h0002);
        idle(800);
        chk("R10 eight frames", frames, 8);
        rd(12'h00C, d); chk("R10 rx full tx empty", d, 16'h0F);
        wr(12'h008, 16'h7E01);
        wr(12'h008, 16'h7E02);
        idle(300);
        chk("R10 stalled", frames, 8);
        rd(12'h00C, d); chk("R10 stall status", d, 16'h1E);
        rd(12'h008, d); chk("R12 rx frame0", d, reply_of(0));
        idle(300);
        chk("R10 one more frame", frames, 9);
        rd(12'h00C, d); chk("R10 still full", d, 16'h1E);
        for (int k = 1; k < 9; k++) begin
            rd(12'h008, d); chk($sformatf("R12 R13 rx frame%0d", k), d, reply_of(k));
        end
        idle(300);
        chk("R10 last frame", frames, 10);
        rd(12'h008, d); chk("R12 rx frame9", d, reply_of(9));
        rd(12'h00C, d); chk("R4 idle again", d, 16'h03);
        chk("R12 period ps0", last_period, 4);
        chk("R12 mosi count", mosi_q.size(), 10);
        for (int i = 0; i < 8; i++)
            chk($sformatf("R12 mosi word %0d", i), mosi_q[i], 16'(16'h1000 + i * 16'h0111));
        chk("R12 mosi word 8", mosi_q[8], 16'h7E01);
        chk("R12 mosi word 9", mosi_q[9], 16'h7E02);

        // R7 R12 4-bit frame, prescale 3
        wr(12'h004, 16'h0000);
        wr(12'h000, 16'h0003);
        wr(12'h010, 16'h0003);
        fs = 4;
        cs_before = cs_low_cycles;
        wr(12'h004, 16'h0002);
        wr(12'h008, 16'hFFAB);
        idle(200);
        chk("R12 frame count", frames, 11);
        chk("R12 cs low span", cs_low_cycles - cs_before, 32);
        chk("R7 tx masked", mosi_q[10], 16'h000B);
        chk("R12 period ps3", last_period, 8);
        rd(12'h008, d); chk("R7 rx masked", d, reply_of(10) & mask_of(4));

        chk("R12 sclk idle low", pin_viol, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule